// File: doc/BRIEF.md
# Alert-Response Responder for a Serial Management Bus Slave

This block sits beside the byte engine of a two-wire management-bus slave and owns the shared interrupt line of the device. It holds a sticky alert flag. The flag is set by any limit-violation bit or by the open-sensor fault flag. The flag drives an open-drain enable, and several devices can pull the same line low together.

When the master reads the alert-response address, a device with a pending alert acknowledges that address. It then sends a data byte made of its own 7-bit address with a 1 in the lowest bit. It transmits bit by bit and watches the line for arbitration, so the device with the lowest address wins when several answer at once. A device that loses stops driving until the end of the byte and keeps its flag set, so the master can ask again. A device that wins clears its flag at the master's acknowledge slot, but only if no alert cause is active at that moment.

The byte engine supplies the timing. It gives a pulse when an address byte has been received, a pulse when SCL is low and the next bit may be presented, a pulse at the SCL-high sampling point together with the sampled SDA level, and a pulse on a stop condition.

Top module: `ara_responder`

## Requirements
- R1: `alert_drive` is 1 from the clock edge that samples any bit of `limit_alarm` or `open_fault` high, and it stays 1 while any cause is high. After reset it is 0.
- R2: When `hdr_valid` carries `hdr_byte` equal to {ARA_ADDR, 1'b1} (7'b0001100 followed by a read bit of 1) and `alert_drive` is 1, `sda_drive_low` goes to 1 at the next `bit_setup`. It holds there until the following `bit_setup`, which forms the acknowledge.
- R3: When `alert_drive` is 0, an alert-response read is ignored: `sda_drive_low` stays 0 for the whole transfer.
- R4: An address byte other than {ARA_ADDR, 1}, including the response address with the write bit 0, is ignored: `sda_drive_low` stays 0.
- R5: After the acknowledge, each of the next eight `bit_setup` pulses presents one bit of {DEV_ADDR, 1'b1}, most significant bit first. A 0 bit drives the line low (`sda_drive_low`=1) and a 1 bit releases it (`sda_drive_low`=0).
- R6: If a released 1 bit is sampled as 0 at `bit_sample`, the device has lost arbitration. `sda_drive_low` stays 0 for the rest of the byte, and `alert_drive` stays 1 after the transfer.
- R7: After a data byte sent without loss, `sda_drive_low` is 0 during the master acknowledge slot. `alert_drive` falls at the sample of that slot if no cause is high.
- R8: If a cause is still high at that sample, `alert_drive` stays 1.
- R9: `stop_seen` ends any reply: `sda_drive_low` is 0 from the next edge, and the alert flag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| limit_alarm | input | LIMIT_W | Limit-violation causes, one per comparator |
| open_fault | input | 1 | Open-circuit sensor fault cause |
| hdr_valid | input | 1 | Pulse: address byte received |
| hdr_byte | input | 8 | Received 7-bit address and read/write bit (LSB) |
| bit_setup | input | 1 | Pulse: SCL low, present the next bit |
| bit_sample | input | 1 | Pulse: SCL high, SDA sampled |
| sda_in | input | 1 | SDA level at `bit_sample` |
| stop_seen | input | 1 | Pulse: stop condition detected |
| alert_drive | output | 1 | Open-drain enable for the alert line (1 pulls low) |
| sda_drive_low | output | 1 | Open-drain enable for SDA (1 pulls low) |

## Verification
The assertions assume the byte engine's timing is well formed: `bit_setup` and `bit_sample` alternate, and neither arrives in the same cycle as `hdr_valid` or `stop_seen`. They also assume `sda_in` reads 0 whenever the block drives SDA low, as on a real wired-AND bus. The bench produces each pulse as a separate single-cycle event. It computes `sda_in` from a bus model that ANDs the block's drive with a modelled rival responder, which follows the same arbitration rule. It changes the cause inputs only between transfers.

// File: rtl/ara_pkg.sv
package ara_pkg;
   localparam int BYTE_W = 8;
   localparam int IDX_W  = $clog2(BYTE_W);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACK_PEND,
      ST_ACK,
      ST_BIT_PEND,
      ST_BIT,
      ST_MACK_PEND,
      ST_MACK
   } reply_st_e;
endpackage

// File: rtl/ara_alert_latch.sv
module ara_alert_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic cause,
   input  logic clr_req,
   output logic alert
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       alert <= 1'b0;
      else if (cause)   alert <= 1'b1;
      else if (clr_req) alert <= 1'b0;
   end
endmodule

// File: rtl/ara_reply_fsm.sv
module ara_reply_fsm
   import ara_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] reply,
   input  logic              bit_setup,
   input  logic              bit_sample,
   input  logic              sda_in,
   input  logic              stop_seen,
   output logic              drive_low,
   output logic              win_done
);
   reply_st_e        st;
   logic [IDX_W-1:0] idx;
   logic             lost;

   assign win_done = (st == ST_MACK) && bit_sample && !lost && !stop_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         lost      <= 1'b0;
         drive_low <= 1'b0;
      end else if (stop_seen) begin
         st        <= ST_IDLE;
         lost      <= 1'b0;
         drive_low <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st   <= ST_ACK_PEND;
               lost <= 1'b0;
            end
            ST_ACK_PEND: if (bit_setup) begin
               drive_low <= 1'b1;
               st        <= ST_ACK;
            end
            ST_ACK: if (bit_sample) begin
               idx <= IDX_W'(BYTE_W - 1);
               st  <= ST_BIT_PEND;
            end
            ST_BIT_PEND: if (bit_setup) begin
               drive_low <= !lost && !reply[idx];
               st        <= ST_BIT;
            end
            ST_BIT: if (bit_sample) begin
               if (!lost && reply[idx] && !sda_in) lost <= 1'b1;
               if (idx == '0) st <= ST_MACK_PEND;
               else begin
                  idx <= idx - 1'b1;
                  st  <= ST_BIT_PEND;
               end
            end
            ST_MACK_PEND: if (bit_setup) begin
               drive_low <= 1'b0;
               st        <= ST_MACK;
            end
            ST_MACK: if (bit_sample) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ara_responder.sv
module ara_responder
   import ara_pkg::*;
#(
   parameter int             ADDR_W   = 7,
   parameter int             LIMIT_W  = 4,
   parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h4C,
   parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C,
   parameter bit             FAULT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LIMIT_W-1:0] limit_alarm,
   input  logic               open_fault,
   input  logic               hdr_valid,
   input  logic [7:0]         hdr_byte,
   input  logic               bit_setup,
   input  logic               bit_sample,
   input  logic               sda_in,
   input  logic               stop_seen,
   output logic               alert_drive,
   output logic               sda_drive_low
);
   localparam logic [BYTE_W-1:0] ARA_READ = {ARA_ADDR, 1'b1};
   localparam logic [BYTE_W-1:0] REPLY    = {DEV_ADDR, 1'b1};

   if (ADDR_W + 1 != BYTE_W) begin : g_bad_width
      $error("ADDR_W must be one less than the byte width");
   end
   if (LIMIT_W < 1) begin : g_bad_limit
      $error("LIMIT_W must be at least 1");
   end
   if (DEV_ADDR == ARA_ADDR) begin : g_bad_addr
      $error("DEV_ADDR must differ from the alert response address");
   end

   logic cause;
   logic win_done;
   logic start;

   if (FAULT_EN) begin : g_with_fault
      assign cause = (|limit_alarm) | open_fault;
   end else begin : g_no_fault
      logic unused_fault;
      assign unused_fault = open_fault;
      assign cause        = |limit_alarm;
   end

   assign start = hdr_valid && (hdr_byte == ARA_READ) && alert_drive;

   ara_alert_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause   (cause),
      .clr_req (win_done),
      .alert   (alert_drive)
   );

   ara_reply_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .reply      (REPLY),
      .bit_setup  (bit_setup),
      .bit_sample (bit_sample),
      .sda_in     (sda_in),
      .stop_seen  (stop_seen),
      .drive_low  (sda_drive_low),
      .win_done   (win_done)
   );
endmodule

// File: rtl/ara_responder_chk.sv
module ara_responder_chk #(
   parameter int LIMIT_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [LIMIT_W-1:0] limit_alarm,
   input logic               open_fault,
   input logic               bit_setup,
   input logic               bit_sample,
   input logic               stop_seen,
   input logic               alert_drive,
   input logic               sda_drive_low
);
   p_alert_follows_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|limit_alarm) |=> alert_drive);

   p_drive_moves_on_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_setup && !stop_seen) |=> $stable(sda_drive_low));

   p_no_drive_without_alert_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_drive |-> !sda_drive_low);

   p_clear_at_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alert_drive) |-> $past(bit_sample));

   p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !sda_drive_low);
endmodule

bind ara_responder ara_responder_chk #(.LIMIT_W(LIMIT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .limit_alarm   (limit_alarm),
   .open_fault    (open_fault),
   .bit_setup     (bit_setup),
   .bit_sample    (bit_sample),
   .stop_seen     (stop_seen),
   .alert_drive   (alert_drive),
   .sda_drive_low (sda_drive_low)
);

// File: tb/sim_ara_responder.sv
`timescale 1ns/1ps
module sim_ara_responder;
   localparam int         LW  = 4;
   localparam logic [6:0] DEV = 7'h4C;
   localparam logic [6:0] ARA = 7'h0C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] limit_alarm = '0;
   logic          open_fault = 1'b0;
   logic          hdr_valid = 1'b0;
   logic [7:0]    hdr_byte = '0;
   logic          bit_setup = 1'b0;
   logic          bit_sample = 1'b0;
   logic          sda_in = 1'b1;
   logic          stop_seen = 1'b0;
   logic          alert_drive;
   logic          sda_drive_low;

   int  n_run = 0;
   int  n_fail = 0;
   bit  lat_m = 1'b0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   ara_responder #(.LIMIT_W(LW), .DEV_ADDR(DEV), .ARA_ADDR(ARA)) u0 (
      .clk(clk), .rst_n(rst_n), .limit_alarm(limit_alarm), .open_fault(open_fault),
      .hdr_valid(hdr_valid), .hdr_byte(hdr_byte), .bit_setup(bit_setup),
      .bit_sample(bit_sample), .sda_in(sda_in), .stop_seen(stop_seen),
      .alert_drive(alert_drive), .sda_drive_low(sda_drive_low)
   );

   function automatic bit reply_bit(input logic [6:0] a, input int i);
      logic [7:0] b;
      b = {a, 1'b1};
      return b[i];
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic setup_pulse();
      bit_setup = 1'b1;
      @(negedge clk);
      bit_setup = 1'b0;
   endtask

   task automatic sample_pulse(input logic v);
      sda_in = v;
      bit_sample = 1'b1;
      @(negedge clk);
      bit_sample = 1'b0;
      sda_in = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_causes(input logic [LW-1:0] lim, input logic f);
      limit_alarm = lim;
      open_fault  = f;
      @(negedge clk);
      if ((|lim) || f) lat_m = 1'b1;
      chk("R1 alert after cause", alert_drive, lat_m);
   endtask

   // One bus transfer with an optional rival responder at address rv
   task automatic txn(input logic [7:0] hdr, input bit rv_on, input logic [6:0] rv);
      bit respond, lost, rv_lost, rv_resp, mine, theirs, bus;
      respond = lat_m && (hdr == {ARA, 1'b1});
      rv_resp = rv_on && (hdr == {ARA, 1'b1});
      lost = 1'b0;
      rv_lost = 1'b0;
      hdr_byte  = hdr;
      hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      @(negedge clk);
      setup_pulse();
      if (hdr == {ARA, 1'b1} && !lat_m) chk("R3 no ack without alert", sda_drive_low, 1'b0);
      else if (hdr != {ARA, 1'b1})      chk("R4 other address ignored", sda_drive_low, 1'b0);
      else                               chk("R2 ack of response address", sda_drive_low, 1'b1);
      @(negedge clk);
      chk("R2 ack held", sda_drive_low, respond);
      sample_pulse(!(sda_drive_low || rv_resp));
      for (int i = 7; i >= 0; i--) begin
         setup_pulse();
         mine   = respond && !lost && !reply_bit(DEV, i);
         theirs = rv_resp && !rv_lost && !reply_bit(rv, i);
         chk(lost ? "R6 released after loss" : "R5 address bit", sda_drive_low, mine);
         bus = !(sda_drive_low || theirs);
         if (respond && !lost && reply_bit(DEV, i) && !bus) lost = 1'b1;
         if (rv_resp && !rv_lost && reply_bit(rv, i) && !bus) rv_lost = 1'b1;
         sample_pulse(bus);
      end
      setup_pulse();
      chk("R7 released in master ack slot", sda_drive_low, 1'b0);
      if (respond && !lost && !((|limit_alarm) || open_fault)) lat_m = 1'b0;
      sample_pulse(1'b0);
      if (respond && lost)       chk("R6 alert kept after loss", alert_drive, lat_m);
      else if (respond && lat_m) chk("R8 alert kept while cause", alert_drive, lat_m);
      else                       chk("R7 alert after response", alert_drive, lat_m);
      stop_seen = 1'b1;
      @(negedge clk);
      stop_seen = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED_0A7A));
      repeat (3) @(negedge clk);
      chk("R1 reset alert", alert_drive, 1'b0);
      chk("R1 reset sda", sda_drive_low, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: response read without a pending alert
      txn({ARA, 1'b1}, 1'b0, 7'h00);
      // R1 + R7: win alone, cause gone
      set_causes(4'b0010, 1'b0);
      set_causes('0, 1'b0);
      txn({ARA, 1'b1}, 1'b0, 7'h00);
      // R4: write bit with the response address
      set_causes('0, 1'b1);
      set_causes('0, 1'b0);
      txn({ARA, 1'b0}, 1'b0, 7'h00);
      // R6: lose to a lower address
      txn({ARA, 1'b1}, 1'b1, 7'h18);
      // R5/R7: win against a higher address
      txn({ARA, 1'b1}, 1'b1, 7'h70);
      // R8: cause still high
      set_causes(4'b1000, 1'b0);
      txn({ARA, 1'b1}, 1'b0, 7'h00);
      // R9: stop during the acknowledge
      hdr_byte = {ARA, 1'b1};
      hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      setup_pulse();
      chk("R2 ack before stop", sda_drive_low, 1'b1);
      stop_seen = 1'b1;
      @(negedge clk);
      stop_seen = 1'b0;
      chk("R9 stop releases sda", sda_drive_low, 1'b0);
      chk("R9 alert kept on stop", alert_drive, 1'b1);
      set_causes('0, 1'b0);
      txn({ARA, 1'b1}, 1'b0, 7'h00);

      // Random mix
      for (int k = 0; k < 60; k++) begin
         logic [7:0] h;
         logic [6:0] rv;
         int sel;
         if ($urandom_range(1, 0) == 1)
            set_causes(LW'($urandom_range(15, 1)), 1'($urandom_range(1, 0)));
         set_causes('0, 1'($urandom_range(3, 0) == 0));
         sel = $urandom_range(19, 0);
         if (sel < 14)      h = {ARA, 1'b1};
         else if (sel < 17) h = {ARA, 1'b0};
         else begin
            h = 8'($urandom_range(255, 0));
            if (h == {ARA, 1'b1}) h = 8'h91;
         end
         rv = 7'($urandom_range(127, 0));
         if (rv == DEV) rv = 7'h7F;
         txn(h, 1'($urandom_range(1, 0)), rv);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule